// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits in the active-low chip-enable path between a host and a battery-backed low-power SRAM. While the supply is good, the host's enable passes straight through to the memory. An external comparator raises a power-fail flag. When the block sees that flag, it drives the memory enable inactive, which write-protects the SRAM. It keeps the enable inactive until power has come back and a stabilization interval has run out. An access that is already under way when power fails may finish, but only for a bounded number of cycles.

A second external flag reports that the supply has dropped below the battery switchover point. The block brings this flag out as a battery-select indication. Both flags are asynchronous and pass through a two-flop synchronizer. The drain timeout and the recovery hold are parameters counted in clock cycles.

Top module: `pfce_gate`

## Requirements
- R1: In the pass state (supply good, no hold running), `mem_ce_no` equals `host_ce_ni` in the same cycle.
- R2: When power fail is seen while the host enable is idle (high), `mem_ce_no` stays high from then on, whatever the host does, until the recovery hold ends.
- R3: When power fail is seen while the host enable is active (low), `mem_ce_no` keeps following the host until the host releases the enable. From that point the output is forced high.
- R4: If the host holds the enable low after power fail is seen, `mem_ce_no` is forced high after `WPT_CYCLES` cycles of draining. Counted from the cycle in which `pwr_fail_i` is first driven high, the output stays low for exactly `WPT_CYCLES`+3 cycles.
- R5: `bat_sel_o` equals `swover_i` delayed by two clock cycles.
- R6: After `pwr_fail_i` falls, `mem_ce_no` stays high for exactly `REC_CYCLES`+3 cycles, counted from the cycle of the fall, even with the host enable held low. After that it follows the host again.
- R7: If power fail returns during the recovery hold, the block goes back to protection. On the next fall of `pwr_fail_i`, the full hold of R6 runs again from zero.
- R8: A host enable that goes low while the block is draining an access or protecting the memory never reaches `mem_ce_no`.
- R9: During reset, `mem_ce_no` and `forced_o` are 1 and `bat_sel_o` is 0. After release, with power good, `mem_ce_no` is held high for exactly `REC_CYCLES` cycles, counting the release cycle.
- R10: `forced_o` is 1 exactly while the block holds `mem_ce_no` high on its own, that is during protection or recovery. It is 0 while the output follows the host.
- R11: `pwr_fail_i` acts only after two synchronizer stages. With the host idle, `forced_o` is still 0 two cycles after the flag rises and is 1 in the third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_ce_ni | input | 1 | Host chip enable, active low |
| pwr_fail_i | input | 1 | Asynchronous power-fail flag from the comparator |
| swover_i | input | 1 | Asynchronous battery switchover flag |
| mem_ce_no | output | 1 | Conditioned chip enable to the SRAM, active low |
| bat_sel_o | output | 1 | Battery-select indication (synchronized switchover flag) |
| forced_o | output | 1 | High while the block forces the enable inactive |

## Verification
The hardest situation to reach from the ports is a power fail that comes back during the recovery hold, just after an access has drained to its timeout. Random flag toggling seldom lines these events up with the right phase. The directed part of the bench therefore holds the host enable low through a power fail until the timeout expires. It then drops the flag, lets part of the hold pass, and raises the flag again. It measures the length of the final hold. Constrained-random phases with long flag runs and sticky host enables follow, and a cycle-accurate model written from the requirements checks every output in every cycle.

// File: rtl/pfce_pkg.sv
package pfce_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfce_state_e;
endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfce_timer.sv
module pfce_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/pfce_fsm.sv
module pfce_fsm
  import pfce_pkg::*;
#(
  parameter int WPT_CYCLES = 16,
  parameter int REC_CYCLES = 64,
  parameter int CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pf_s_i,
  input  logic             host_ce_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output pfce_state_e      state_q_o,
  output logic             clr_o,
  output logic             inc_o
);
  localparam logic [CNT_W-1:0] WptLast = CNT_W'(WPT_CYCLES - 1);
  localparam logic [CNT_W-1:0] RecLast = CNT_W'(REC_CYCLES - 1);

  pfce_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (pf_s_i) state_d = host_ce_ni ? ST_PROTECT : ST_DRAIN;
      ST_DRAIN:   if (host_ce_ni || cnt_i == WptLast) state_d = ST_PROTECT;
      ST_PROTECT: if (!pf_s_i) state_d = ST_RECOVER;
      ST_RECOVER: begin
        if (pf_s_i)                state_d = ST_PROTECT;
        else if (cnt_i == RecLast) state_d = ST_NORMAL;
      end
      default:    state_d = ST_RECOVER;
    endcase
  end

  // reset lands in RECOVER so power-up always gets the full hold
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_RECOVER;
    else         state_q <= state_d;

  assign state_q_o = state_q;
  assign clr_o     = (state_d != state_q);
  assign inc_o     = (state_q == ST_DRAIN) || (state_q == ST_RECOVER);

  p_drain_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && $past(state_q) != ST_DRAIN)
      |-> ($past(state_q) == ST_NORMAL && !$past(host_ce_ni)));

  p_drain_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> (cnt_i < CNT_W'(WPT_CYCLES)));

  p_protect_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROTECT && pf_s_i) |=> (state_q == ST_PROTECT));

  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && $past(state_q) == ST_RECOVER)
      |-> ($past(cnt_i) == RecLast));
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
  import pfce_pkg::*;
#(
  parameter int WPT_CYCLES = 2000,
  parameter int REC_CYCLES = 24_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_ce_ni,
  input  logic pwr_fail_i,
  input  logic swover_i,
  output logic mem_ce_no,
  output logic bat_sel_o,
  output logic forced_o
);
  localparam int MaxCyc = (WPT_CYCLES > REC_CYCLES) ? WPT_CYCLES : REC_CYCLES;
  localparam int CntW   = $clog2(MaxCyc + 1);

  logic [1:0]      flags_s;
  logic            pf_s;
  logic [CntW-1:0] cnt;
  logic            clr, inc;
  pfce_state_e     state;

  pfce_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({swover_i, pwr_fail_i}),
    .q_o    (flags_s)
  );

  assign pf_s      = flags_s[0];
  assign bat_sel_o = flags_s[1];

  pfce_fsm #(
    .WPT_CYCLES (WPT_CYCLES),
    .REC_CYCLES (REC_CYCLES),
    .CNT_W      (CntW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pf_s_i     (pf_s),
    .host_ce_ni (host_ce_ni),
    .cnt_i      (cnt),
    .state_q_o  (state),
    .clr_o      (clr),
    .inc_o      (inc)
  );

  pfce_timer #(.CNT_W(CntW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .cnt_o  (cnt)
  );

  assign forced_o  = (state == ST_PROTECT) || (state == ST_RECOVER);
  assign mem_ce_no = forced_o ? 1'b1 : host_ce_ni;

  p_forced_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_o |-> mem_ce_no);
endmodule

// File: tb/pfce_gate_bench.sv
`timescale 1ns/1ps
module pfce_gate_bench;
  localparam int WPT = 6;
  localparam int REC = 10;
  localparam int S_NORM = 0, S_DRAIN = 1, S_PROT = 2, S_REC = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_ce_ni = 1'b1, pwr_fail_i = 1'b0, swover_i = 1'b0;
  logic mem_ce_no, bat_sel_o, forced_o;

  int n_chk = 0, n_fail = 0;
  int m_st, m_cnt;
  bit m_pf1, m_pf2, m_sw1, m_sw2;

  always #2.5 clk = ~clk;

  pfce_gate #(.WPT_CYCLES(WPT), .REC_CYCLES(REC)) u_pfce_gate (
    .clk_i(clk), .rst_ni(rst_ni), .host_ce_ni(host_ce_ni),
    .pwr_fail_i(pwr_fail_i), .swover_i(swover_i),
    .mem_ce_no(mem_ce_no), .bat_sel_o(bat_sel_o), .forced_o(forced_o)
  );

  function automatic int next_st(int st, bit pf, bit h, int cnt);
    case (st)
      S_NORM:  return pf ? (h ? S_PROT : S_DRAIN) : S_NORM;
      S_DRAIN: return (h || cnt == WPT - 1) ? S_PROT : S_DRAIN;
      S_PROT:  return pf ? S_PROT : S_REC;
      default: return pf ? S_PROT : ((cnt == REC - 1) ? S_NORM : S_REC);
    endcase
  endfunction

  function automatic bit exp_ce(int st, bit h);
    return (st == S_NORM || st == S_DRAIN) ? h : 1'b1;
  endfunction

  function automatic bit exp_forced(int st);
    return (st == S_PROT || st == S_REC);
  endfunction

  function automatic string ce_tag(int st);
    case (st)
      S_NORM:  return "R1";
      S_DRAIN: return "R3";
      S_PROT:  return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = S_REC; m_cnt = 0;
    m_pf1 = 0; m_pf2 = 0; m_sw1 = 0; m_sw2 = 0;
  endtask

  task automatic model_update(input bit h, input bit p, input bit s);
    int nx;
    nx = next_st(m_st, m_pf2, h, m_cnt);
    if (nx != m_st) m_cnt = 0;
    else if (m_st == S_DRAIN || m_st == S_REC) m_cnt++;
    m_st = nx;
    m_pf2 = m_pf1; m_pf1 = p;
    m_sw2 = m_sw1; m_sw1 = s;
  endtask

  task automatic sample_all(input bit h, output logic ce);
    #1;
    check(mem_ce_no, exp_ce(m_st, h), ce_tag(m_st));
    check(forced_o, exp_forced(m_st), "R10");
    check(bat_sel_o, m_sw2, "R5");
    ce = mem_ce_no;
  endtask

  task automatic step(input bit h, input bit p, input bit s, output logic ce);
    @(negedge clk);
    host_ce_ni = h; pwr_fail_i = p; swover_i = s;
    sample_all(h, ce);
    @(posedge clk);
    model_update(h, p, s);
  endtask

  // count leading cycles in which mem_ce_no equals lvl
  task automatic run_count(input bit h, input bit p, input int n, input logic lvl,
                           output int run);
    logic c;
    bit broken = 0;
    run = 0;
    for (int k = 0; k < n; k++) begin
      step(h, p, 1'b0, c);
      if (!broken && c === lvl) run++;
      else broken = 1;
    end
  endtask

  task automatic do_reset();
    int run;
    logic c;
    @(negedge clk);
    rst_ni = 1'b0; host_ce_ni = 1'b0; pwr_fail_i = 1'b1; swover_i = 1'b1;
    model_reset();
    repeat (3) begin
      @(negedge clk); #1;
      check(mem_ce_no, 1'b1, "R9");
      check(forced_o, 1'b1, "R9");
      check(bat_sel_o, 1'b0, "R9");
    end
    @(negedge clk);
    rst_ni = 1'b1; host_ce_ni = 1'b0; pwr_fail_i = 1'b0; swover_i = 1'b0;
    sample_all(1'b0, c);
    @(posedge clk);
    model_update(1'b0, 1'b0, 1'b0);
    run_count(1'b0, 1'b0, REC + 4, 1'b1, run);
    check_int(run + (c === 1'b1 ? 1 : 0), REC, "R9");
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int run;
    logic c;
    bit h, p, s;
    void'($urandom(32'd9137));
    do_reset();

    // R1: pass-through pattern
    for (int k = 0; k < 8; k++) step(bit'(k % 3 == 0), 1'b0, 1'b0, c);

    // R11 / R2: idle host, sync latency, then host tries to access
    step(1'b1, 1'b1, 1'b0, c);
    step(1'b1, 1'b1, 1'b0, c);
    step(1'b1, 1'b1, 1'b0, c); #0 check(forced_o, 1'b0, "R11");
    step(1'b1, 1'b1, 1'b0, c); #0 check(forced_o, 1'b1, "R11");
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1, 1'b0, c);
      check(c, 1'b1, "R2");
    end

    // R6: hold after power returns, host held low
    run_count(1'b0, 1'b0, REC + 6, 1'b1, run);
    check_int(run, REC + 3, "R6");

    // R3: access underway finishes early, then new enable blocked (R8)
    step(1'b0, 1'b1, 1'b0, c);
    step(1'b0, 1'b1, 1'b0, c);
    step(1'b0, 1'b1, 1'b0, c);
    step(1'b0, 1'b1, 1'b0, c); #0 check(c, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, c); check(c, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, c); check(c, 1'b1, "R8");
    run_count(1'b0, 1'b0, REC + 6, 1'b1, run);

    // R4: access never ends, timeout forces the output
    run_count(1'b0, 1'b1, WPT + 8, 1'b0, run);
    check_int(run, WPT + 3, "R4");

    // R7: power fail returns mid-hold, hold restarts from zero
    for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, c);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, c);
    run_count(1'b0, 1'b0, REC + 6, 1'b1, run);
    check_int(run, REC + 3, "R7");

    // random phase, model checks every cycle
    h = 1; p = 0; s = 0;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 39) == 0) p = ~p;
      if ($urandom_range(0, 29) == 0) s = ~s;
      if ($urandom_range(0, 3) == 0)  h = ~h;
      step(h, p, s, c);
    end

    do_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule